// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds eight one-bit hardware locks that a left and a right port share. Each port picks a lock with a 3-bit index and writes to it. A write with data bit 0 cleared asks for the lock, and a write with data bit 0 set gives it back. A read returns the port's own view of that lock on every data bit. The view is 0 when this port holds the lock and 1 when it does not. Two agents can use the bank to claim a shared resource without racing each other.

Each port keeps a pending-request latch for every lock. A request that hits a lock the other side holds is remembered. When the holder gives the lock back, the token passes straight to the waiting port on the same clock edge. A write from the port that does not hold a lock never moves its ownership. An access counts only while the lock-select strobe is low and the memory chip enable is inactive (high). A port issues either a read or a write in a cycle, chosen by its write strobe.

Top module: `hwlock_bank`

## Requirements
- R1: There are eight locks, numbered 0 to 7 by the 3-bit index of each port. An access happens only in a cycle where that port's select (`*_sel_n`) is 0 and its memory enable (`*_mem_en_n`) is 1.
- R2: A qualified write with data bit 0 = 0 is a request and with data bit 0 = 1 is a release. Data bits 7..1 have no effect.
- R3: A qualified read (`*_wr` = 0) loads the output register at the clock edge with the lock's state before that edge, on all 8 bits: 8'h00 if this port holds the lock, 8'hFF otherwise. In any other cycle the output holds its value.
- R4: A free lock reads 1 on both ports. Once the left port holds it, the left reads 0 and the right reads 1. The mirror holds for a right-side grant.
- R5: A request on a lock the other port holds leaves ownership unchanged and sets the requester's pending latch.
- R6: A release by the holder while the other port has a request pending passes ownership to that port at the same edge.
- R7: A release by the holder with no request pending from the other port leaves the lock free.
- R8: A release by a non-holder clears that port's own pending latch and never changes ownership.
- R9: If both ports request a free lock in the same cycle, the left port gets it and the right request stays pending.
- R10: Synchronous reset makes every lock free, clears every pending latch and sets both read outputs to 8'hFF.
- R11: A cycle where select is 1 or memory enable is 0 changes no lock state and leaves the read output unchanged.
- R12: The locks are independent. An access to one index never changes another index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel_n | input | 1 | Left lock-select strobe, active low |
| l_mem_en_n | input | 1 | Left memory chip enable, must be 1 for a lock access |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_idx | input | 3 | Left lock index |
| l_wdata | input | 8 | Left write data, bit 0 significant |
| l_rdata | output | 8 | Left registered lock view |
| r_sel_n | input | 1 | Right lock-select strobe, active low |
| r_mem_en_n | input | 1 | Right memory chip enable, must be 1 for a lock access |
| r_wr | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_idx | input | 3 | Right lock index |
| r_wdata | input | 8 | Right write data, bit 0 significant |
| r_rdata | output | 8 | Right registered lock view |

## Verification
A write changes lock state at the first clock edge after it is presented. A read registers the pre-edge state at that same edge, so its result is on `*_rdata` one cycle after the read is driven. The effect of a write is therefore visible through a read issued in the next cycle, two edges after the write. The bench drives each step on the falling edge, lets one rising edge pass, and compares both read outputs on the following falling edge. Because the outputs hold between reads, write-only and unqualified steps are checked too: the held value must stay unchanged.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;

    // Who currently holds a lock
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Which port an instance serves
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Per-lock stored state
    typedef struct packed {
        owner_e owner;
        logic   pend_l;
        logic   pend_r;
    } lock_state_t;

    // Decoded write actions for one lock in one cycle
    typedef struct packed {
        logic l_take;
        logic l_give;
        logic r_take;
        logic r_give;
    } lock_ops_t;

    localparam lock_state_t LOCK_RESET = '{owner: OWN_NONE, pend_l: 1'b0, pend_r: 1'b0};

    // Next state of one lock given this cycle's write actions
    function automatic lock_state_t lock_step(input lock_state_t cur, input lock_ops_t ops);
        lock_state_t nxt;
        logic   want_l;
        logic   want_r;
        owner_e base;
        want_l = (cur.pend_l | ops.l_take) & ~ops.l_give;
        want_r = (cur.pend_r | ops.r_take) & ~ops.r_give;
        base   = cur.owner;
        if ((cur.owner == OWN_LEFT && ops.l_give) ||
            (cur.owner == OWN_RIGHT && ops.r_give)) begin
            base = OWN_NONE;
        end
        nxt.owner = base;
        if (base == OWN_NONE) begin
            if (want_l)      nxt.owner = OWN_LEFT;
            else if (want_r) nxt.owner = OWN_RIGHT;
        end
        nxt.pend_l = want_l & (nxt.owner != OWN_LEFT);
        nxt.pend_r = want_r & (nxt.owner != OWN_RIGHT);
        return nxt;
    endfunction

    // Port view: 0 when the asking side holds the lock
    function automatic logic lock_view(input owner_e owner, input side_e side);
        logic held;
        held = (side == SIDE_LEFT) ? (owner == OWN_LEFT) : (owner == OWN_RIGHT);
        return ~held;
    endfunction

endpackage

// File: rtl/hwlock_port_dec.sv
module hwlock_port_dec #(
    parameter int N_LOCKS = 8,
    parameter int IDX_W   = 3,
    parameter int DATA_W  = 8
) (
    input  logic              sel_n,
    input  logic              mem_en_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_LOCKS-1:0] take_v,
    output logic [N_LOCKS-1:0] give_v,
    output logic              rd_hit
);

    logic access;
    logic wr_hit;
    logic unused_hi;

    assign access    = ~sel_n & mem_en_n;
    assign wr_hit    = access & wr;
    assign rd_hit    = access & ~wr;
    assign unused_hi = ^wdata[DATA_W-1:1];

    for (genvar g = 0; g < N_LOCKS; g++) begin : g_dec
        logic match;
        assign match     = (idx == IDX_W'(g));
        assign take_v[g] = wr_hit & match & ~wdata[0];
        assign give_v[g] = wr_hit & match &  wdata[0];
    end

endmodule

// File: rtl/hwlock_cell.sv
module hwlock_cell
    import hwlock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lock_ops_t   ops,
    output lock_state_t state
);

    lock_state_t state_q;
    lock_state_t state_d;

    always_comb begin
        state_d = lock_step(state_q, ops);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LOCK_RESET;
        else     state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/hwlock_rd_port.sv
module hwlock_rd_port
    import hwlock_pkg::*;
#(
    parameter int    N_LOCKS = 8,
    parameter int    IDX_W   = 3,
    parameter int    DATA_W  = 8,
    parameter side_e SIDE    = SIDE_LEFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  logic [IDX_W-1:0]  idx,
    input  owner_e            owners [N_LOCKS],
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rdata_q;
    logic              view;

    always_comb begin
        view = 1'b1;
        for (int k = 0; k < N_LOCKS; k++) begin
            if (idx == IDX_W'(k)) view = lock_view(owners[k], SIDE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '1;
        else if (rd_hit) rdata_q <= {DATA_W{view}};
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int N_LOCKS = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(N_LOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel_n,
    input  logic              l_mem_en_n,
    input  logic              l_wr,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel_n,
    input  logic              r_mem_en_n,
    input  logic              r_wr,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    logic [N_LOCKS-1:0] l_take_v, l_give_v, r_take_v, r_give_v;
    logic [N_LOCKS-1:0] own_l_v, own_r_v, pend_l_v, pend_r_v;
    logic               l_rd_hit, r_rd_hit;
    owner_e             owners [N_LOCKS];

    hwlock_port_dec #(.N_LOCKS(N_LOCKS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec_l (
        .sel_n(l_sel_n), .mem_en_n(l_mem_en_n), .wr(l_wr), .idx(l_idx),
        .wdata(l_wdata), .take_v(l_take_v), .give_v(l_give_v), .rd_hit(l_rd_hit)
    );

    hwlock_port_dec #(.N_LOCKS(N_LOCKS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec_r (
        .sel_n(r_sel_n), .mem_en_n(r_mem_en_n), .wr(r_wr), .idx(r_idx),
        .wdata(r_wdata), .take_v(r_take_v), .give_v(r_give_v), .rd_hit(r_rd_hit)
    );

    for (genvar g = 0; g < N_LOCKS; g++) begin : g_lock
        lock_ops_t   ops;
        lock_state_t st;
        assign ops = '{l_take: l_take_v[g], l_give: l_give_v[g],
                       r_take: r_take_v[g], r_give: r_give_v[g]};
        hwlock_cell u_cell (.clk(clk), .rst(rst), .ops(ops), .state(st));
        assign owners[g]   = st.owner;
        assign own_l_v[g]  = (st.owner == OWN_LEFT);
        assign own_r_v[g]  = (st.owner == OWN_RIGHT);
        assign pend_l_v[g] = st.pend_l;
        assign pend_r_v[g] = st.pend_r;
    end

    hwlock_rd_port #(.N_LOCKS(N_LOCKS), .IDX_W(IDX_W), .DATA_W(DATA_W), .SIDE(SIDE_LEFT)) u_rd_l (
        .clk(clk), .rst(rst), .rd_hit(l_rd_hit), .idx(l_idx), .owners(owners), .rdata(l_rdata)
    );

    hwlock_rd_port #(.N_LOCKS(N_LOCKS), .IDX_W(IDX_W), .DATA_W(DATA_W), .SIDE(SIDE_RIGHT)) u_rd_r (
        .clk(clk), .rst(rst), .rd_hit(r_rd_hit), .idx(r_idx), .owners(owners), .rdata(r_rdata)
    );

endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
    parameter int N_LOCKS = 8,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               l_sel_n,
    input logic               l_mem_en_n,
    input logic               r_sel_n,
    input logic               r_mem_en_n,
    input logic [N_LOCKS-1:0] l_take_v,
    input logic [N_LOCKS-1:0] l_give_v,
    input logic [N_LOCKS-1:0] r_take_v,
    input logic [N_LOCKS-1:0] r_give_v,
    input logic [N_LOCKS-1:0] own_l_v,
    input logic [N_LOCKS-1:0] own_r_v,
    input logic [N_LOCKS-1:0] pend_l_v,
    input logic [N_LOCKS-1:0] pend_r_v,
    input logic [DATA_W-1:0]  l_rdata,
    input logic [DATA_W-1:0]  r_rdata
);

    assert_unqualified_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (l_sel_n || !l_mem_en_n) |-> (l_take_v == '0 && l_give_v == '0));

    assert_unqualified_quiet_r_R11: assert property (@(posedge clk) disable iff (rst)
        (r_sel_n || !r_mem_en_n) |-> (r_take_v == '0 && r_give_v == '0));

    assert_replicated_view_R3: assert property (@(posedge clk) disable iff (rst)
        (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

    assert_reset_clean_R10: assert property (@(posedge clk)
        $past(rst) |-> (own_l_v == '0 && own_r_v == '0 && pend_l_v == '0 && pend_r_v == '0));

    for (genvar g = 0; g < N_LOCKS; g++) begin : g_chk
        assert_held_left_kept_R5: assert property (@(posedge clk) disable iff (rst)
            (own_l_v[g] && r_take_v[g] && !l_give_v[g]) |=> (own_l_v[g] && pend_r_v[g]));

        assert_held_right_kept_R5: assert property (@(posedge clk) disable iff (rst)
            (own_r_v[g] && l_take_v[g] && !r_give_v[g]) |=> (own_r_v[g] && pend_l_v[g]));

        assert_handoff_to_right_R6: assert property (@(posedge clk) disable iff (rst)
            (own_l_v[g] && l_give_v[g] && pend_r_v[g] && !r_give_v[g]) |=> own_r_v[g]);

        assert_handoff_to_left_R6: assert property (@(posedge clk) disable iff (rst)
            (own_r_v[g] && r_give_v[g] && pend_l_v[g] && !l_give_v[g]) |=> own_l_v[g]);

        assert_release_frees_R7: assert property (@(posedge clk) disable iff (rst)
            (own_l_v[g] && l_give_v[g] && !pend_r_v[g] && !r_take_v[g])
            |=> (!own_l_v[g] && !own_r_v[g]));

        assert_nonowner_release_R8: assert property (@(posedge clk) disable iff (rst)
            (own_l_v[g] && r_give_v[g] && !l_give_v[g]) |=> (own_l_v[g] && !pend_r_v[g]));

        assert_tie_to_left_R9: assert property (@(posedge clk) disable iff (rst)
            (!own_l_v[g] && !own_r_v[g] && l_take_v[g] && r_take_v[g])
            |=> (own_l_v[g] && pend_r_v[g]));

        assert_idle_lock_stable_R12: assert property (@(posedge clk) disable iff (rst)
            (!l_take_v[g] && !l_give_v[g] && !r_take_v[g] && !r_give_v[g])
            |=> ($stable(own_l_v[g]) && $stable(own_r_v[g]) &&
                 $stable(pend_l_v[g]) && $stable(pend_r_v[g])));
    end

endmodule

bind hwlock_bank hwlock_bank_chk #(.N_LOCKS(N_LOCKS), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst),
    .l_sel_n(l_sel_n), .l_mem_en_n(l_mem_en_n),
    .r_sel_n(r_sel_n), .r_mem_en_n(r_mem_en_n),
    .l_take_v(l_take_v), .l_give_v(l_give_v),
    .r_take_v(r_take_v), .r_give_v(r_give_v),
    .own_l_v(own_l_v), .own_r_v(own_r_v),
    .pend_l_v(pend_l_v), .pend_r_v(pend_r_v),
    .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/hwlock_bank_tb.sv
module hwlock_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_STEPS    = 27;

    // Step layout: [13] l_act [12] l_wr [11:9] l_idx [8] l_bit
    //              [7]  r_act [6]  r_wr [5:3]  r_idx [2] r_bit
    //              [1]  exp_l [0]  exp_r   (expected view bits after the edge)
    localparam logic [13:0] STEPS [N_STEPS] = '{
        14'b1_0_000_0_1_0_000_0_1_1, //  0 R4 free reads 1/1
        14'b1_1_000_0_1_0_000_0_1_1, //  1 L requests 0, R reads pre-edge (R3)
        14'b1_0_000_0_1_0_000_0_0_1, //  2 R4 L holds
        14'b1_0_000_0_1_1_000_0_0_1, //  3 R blocked request (R5)
        14'b1_0_000_0_1_0_000_0_0_1, //  4 R5 ownership kept
        14'b1_1_000_1_0_0_000_0_0_1, //  5 L releases, R pending (R6)
        14'b1_0_000_0_1_0_000_0_1_0, //  6 R6 handed to R
        14'b1_1_000_1_0_0_000_0_1_0, //  7 L non-owner release (R8)
        14'b1_0_000_0_1_0_000_0_1_0, //  8 R8 no change
        14'b1_1_000_0_0_0_000_0_1_0, //  9 L pending request
        14'b0_0_000_0_1_1_000_1_1_0, // 10 R releases, L pending (R6)
        14'b1_0_000_0_1_0_000_0_0_1, // 11 R6 handed to L
        14'b0_0_000_0_1_1_000_0_0_1, // 12 R pending request
        14'b0_0_000_0_1_1_000_1_0_1, // 13 R non-owner release clears pending (R8)
        14'b1_1_000_1_0_0_000_0_0_1, // 14 L releases with nothing pending (R7)
        14'b1_0_000_0_1_0_000_0_1_1, // 15 R7 free
        14'b1_1_011_0_1_1_011_0_1_1, // 16 tie on lock 3 (R9)
        14'b1_0_011_0_1_0_011_0_0_1, // 17 R9 left wins
        14'b1_1_011_1_0_0_000_0_0_1, // 18 L release, R pending from tie (R9)
        14'b1_0_011_0_1_0_011_0_1_0, // 19 R9 right got it
        14'b0_0_000_0_1_1_011_1_1_0, // 20 R release frees (R7)
        14'b1_0_011_0_1_0_011_0_1_1, // 21 R7 free
        14'b1_1_101_0_1_1_110_0_1_1, // 22 L takes 5, R takes 6 (R12)
        14'b1_0_101_0_1_0_110_0_0_0, // 23 R12 both hold their own
        14'b1_0_110_0_1_0_101_0_1_1, // 24 R12 each sees the other's lock as not held
        14'b1_1_101_1_1_1_110_1_1_1, // 25 both release
        14'b1_0_101_0_1_0_110_0_1_1  // 26 R12 both free
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       l_sel_n, l_mem_en_n, l_wr, r_sel_n, r_mem_en_n, r_wr;
    logic [2:0] l_idx, r_idx;
    logic [7:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    logic done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hwlock_bank dut_i (
        .clk(clk), .rst(rst),
        .l_sel_n(l_sel_n), .l_mem_en_n(l_mem_en_n), .l_wr(l_wr), .l_idx(l_idx),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_mem_en_n(r_mem_en_n), .r_wr(r_wr), .r_idx(r_idx),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_sel_n = 1'b1; l_mem_en_n = 1'b1; l_wr = 1'b0; l_idx = '0; l_wdata = '0;
        r_sel_n = 1'b1; r_mem_en_n = 1'b1; r_wr = 1'b0; r_idx = '0; r_wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic left_op(input logic wr, input logic [2:0] idx, input logic [7:0] wd);
        l_sel_n = 1'b0; l_mem_en_n = 1'b1; l_wr = wr; l_idx = idx; l_wdata = wd;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        @(negedge clk);
        tick();
        rst = 1'b0;
        check8("R10 reset left view", l_rdata, 8'hFF);
        check8("R10 reset right view", r_rdata, 8'hFF);

        for (int s = 0; s < N_STEPS; s++) begin
            logic [13:0] v;
            v = STEPS[s];
            l_sel_n = ~v[13]; l_mem_en_n = 1'b1; l_wr = v[12]; l_idx = v[11:9];
            l_wdata = {7'b1010101, v[8]};
            r_sel_n = ~v[7];  r_mem_en_n = 1'b1; r_wr = v[6];  r_idx = v[5:3];
            r_wdata = {7'b0101010, v[2]};
            tick();
            check8($sformatf("R3 table step %0d left", s), l_rdata, {8{v[1]}});
            check8($sformatf("R3 table step %0d right", s), r_rdata, {8{v[0]}});
        end

        // R2: upper data bits do not matter; 8'hFE requests, 8'h01 releases
        idle(); left_op(1'b1, 3'd7, 8'hFE); tick();
        idle(); left_op(1'b0, 3'd7, 8'h00); tick();
        check8("R2 request with 8'hFE", l_rdata, 8'h00);

        // R11: select high write and enable low read have no effect
        idle(); l_sel_n = 1'b1; l_wr = 1'b1; l_idx = 3'd7; l_wdata = 8'hFF; tick();
        check8("R11 select-high write keeps output", l_rdata, 8'h00);
        idle(); left_op(1'b0, 3'd0, 8'h00); l_mem_en_n = 1'b0; tick();
        check8("R11 enable-low read keeps output", l_rdata, 8'h00);
        idle(); left_op(1'b1, 3'd7, 8'h01); l_mem_en_n = 1'b0; tick();
        idle(); left_op(1'b0, 3'd7, 8'h00); tick();
        check8("R11 lock 7 still held after unqualified writes", l_rdata, 8'h00);

        idle(); left_op(1'b1, 3'd7, 8'h01); tick();
        idle(); left_op(1'b0, 3'd7, 8'h00); tick();
        check8("R2 release with 8'h01", l_rdata, 8'hFF);

        // R10: reset mid-run frees held locks and drops pending requests
        idle(); left_op(1'b1, 3'd2, 8'h00); tick();
        idle(); r_sel_n = 1'b0; r_wr = 1'b1; r_idx = 3'd2; r_wdata = 8'h00; tick();
        idle(); left_op(1'b0, 3'd2, 8'h00); tick();
        check8("R10 precondition lock 2 held", l_rdata, 8'h00);
        idle(); rst = 1'b1; tick(); rst = 1'b0;
        check8("R10 mid-run reset left view", l_rdata, 8'hFF);
        check8("R10 mid-run reset right view", r_rdata, 8'hFF);
        idle(); r_sel_n = 1'b0; r_wr = 1'b0; r_idx = 3'd2; left_op(1'b0, 3'd2, 8'h00); tick();
        check8("R10 lock 2 free for left", l_rdata, 8'hFF);
        check8("R10 right pending dropped", r_rdata, 8'hFF);

        // R1: index selects lock, lock 4 taken by right is seen only at index 4
        idle(); r_sel_n = 1'b0; r_wr = 1'b1; r_idx = 3'd4; r_wdata = 8'h00; tick();
        idle(); r_sel_n = 1'b0; r_idx = 3'd4; left_op(1'b0, 3'd4, 8'h00); tick();
        check8("R1 right holds lock 4", r_rdata, 8'h00);
        check8("R1 left sees lock 4 held by other", l_rdata, 8'hFF);
        idle(); r_sel_n = 1'b0; r_idx = 3'd1; tick();
        check8("R1 right does not hold lock 1", r_rdata, 8'hFF);

        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule